// File: doc/BRIEF.md
# ADC Conversion Command Queue Sequencer

This block walks a queue of conversion command words kept in a local 128-entry command memory. For each command it sends one start request to an external converter, then waits for that converter's done pulse. Each command word holds a channel number and a pause flag. A reserved channel code (all ones) ends the queue, and so does the last memory address.

Software arms a single scan through a 16-bit control register. After the arm, a trigger input starts the queue at the programmed begin pointer. A command whose pause flag is set stops the queue after its conversion, and a later trigger continues the queue. A preempt input aborts the conversion in flight. When preempt is released, execution restarts either at the aborted command or at the start of the current sub-queue. Completion and pause events set sticky flags. Software clears these flags by writing one to them, and each flag reaches its interrupt output only while its enable bit is set.

Top module: `adc_cmd_sequencer`

## Requirements
- R1: After reset, ctl_rdata reads 16'h007F (all fields zero, begin pointer 127), conv_start is low and both interrupt outputs are low.
- R2: Control register layout, vector index 15 down to 0: [15] completion enable, [14] pause enable, [13] scan arm, [12:8] mode, [7] resume policy, [6:0] begin pointer. A write loads all fields, and the other fields read back as written.
- R3: The scan arm bit always reads as zero. Writing one to it arms a scan, and this may happen in the same write that selects the single-scan mode (mode value 1).
- R4: From idle, a trigger starts the queue only when mode is 1 and the arm is set. conv_start for the command at the begin pointer goes high in the cycle after the trigger. A trigger with the arm clear, or with any other mode, starts nothing.
- R5: Command word format: bit 6 is the pause flag and bits 5:0 the channel. The sequencer issues the channels in address order, one single-cycle conv_start per command, and moves to the next address on conv_done.
- R6: The queue completes when a command with channel 63 is reached (that command is not converted) or when the conversion at address 127 finishes. Completion sets the completion flag and clears the arm, so a further trigger starts nothing.
- R7: A trigger that arrives while the queue is executing or suspended is ignored and does not restart the queue.
- R8: When the conversion of a command with its pause flag set finishes, the pause flag is set and no further start is issued until a trigger arrives. Execution then continues at the next address.
- R9: Flags stay set until flag_clr is written (bit 1 clears completion, bit 0 clears pause). irq_cmpl and irq_pause are high only while the matching flag and enable are both set.
- R10: While preempt is high, the conversion in flight is abandoned and no start is issued. On release, resume policy 1 restarts at the aborted command. Policy 0 restarts at the first command after the most recent pause, or at the begin pointer if no pause has been passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 16 | Control register write data |
| ctl_rdata | output | 16 | Control register read data |
| flag_clr | input | 2 | Write-one-to-clear for completion (bit 1) and pause (bit 0) flags |
| ccw_we | input | 1 | Command memory write strobe |
| ccw_addr | input | 7 | Command memory write address |
| ccw_wdata | input | 7 | Command word: pause flag and channel |
| trig | input | 1 | Trigger event |
| preempt | input | 1 | Suspend request, level sensitive |
| conv_start | output | 1 | Single-cycle conversion request |
| conv_chan | output | 6 | Channel for the request |
| conv_done | input | 1 | Converter done pulse |
| irq_cmpl | output | 1 | Queue completion interrupt |
| irq_pause | output | 1 | Queue pause interrupt |

## Verification
The assertions check on every cycle that:
- the arm bit reads as zero;
- each start lasts exactly one cycle;
- no start is issued under preempt;
- an interrupt never rises without its enable;
- a raised flag holds until it is cleared or the register is rewritten.

Only the bench scenarios can show the rest: the channel order for each begin pointer and queue length, the end of a queue at the memory limit, triggers that are ignored, pause and continue, and the two restart positions after preemption.

// File: rtl/adc_cmd_sequencer.sv
module adc_cmd_sequencer #(
  parameter int CH_W = 6,
  parameter logic [4:0] MODE_SINGLE = 5'd1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctl_we,
  input  logic [15:0]     ctl_wdata,
  output logic [15:0]     ctl_rdata,
  input  logic [1:0]      flag_clr,
  input  logic            ccw_we,
  input  logic [6:0]      ccw_addr,
  input  logic [CH_W:0]   ccw_wdata,
  input  logic            trig,
  input  logic            preempt,
  output logic            conv_start,
  output logic [CH_W-1:0] conv_chan,
  input  logic            conv_done,
  output logic            irq_cmpl,
  output logic            irq_pause
);
  localparam int PTR_W = 7;
  localparam int DEPTH = 1 << PTR_W;
  localparam logic [CH_W-1:0] END_CODE = '1;
  localparam logic [PTR_W-1:0] LAST = '1;

  typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_WAIT, S_PAUSE, S_SUSP} st_t;

  st_t st;
  logic cie, pie, arm, res, cflag, pflag;
  logic [4:0] mode;
  logic [PTR_W-1:0] bq, ptr, sub;
  logic [CH_W:0] mem [DEPTH];

  always_ff @(posedge clk)
    if (ccw_we) mem[ccw_addr] <= ccw_wdata;

  wire [CH_W:0] cur = mem[ptr];
  wire cur_end   = cur[CH_W-1:0] == END_CODE;
  wire cur_pause = cur[CH_W];
  wire run_end   = st == S_ISSUE && !preempt && cur_end;
  wire conv_fin  = st == S_WAIT && !preempt && conv_done;
  wire q_done    = run_end || (conv_fin && ptr == LAST);
  wire p_hit     = conv_fin && cur_pause;
  wire go        = st == S_IDLE && trig && arm && mode == MODE_SINGLE;

  assign conv_start = st == S_ISSUE && !cur_end && !preempt;
  assign conv_chan  = cur[CH_W-1:0];
  assign ctl_rdata  = {cie, pie, 1'b0, mode, res, bq};
  assign irq_cmpl   = cflag & cie;
  assign irq_pause  = pflag & pie;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st  <= S_IDLE;
      ptr <= '0;
      sub <= '0;
    end else begin
      case (st)
        S_IDLE:
          if (go) begin
            ptr <= bq;
            sub <= bq;
            st  <= S_ISSUE;
          end
        S_ISSUE:
          if (preempt) begin
            st <= S_SUSP;
            if (!res) ptr <= sub;
          end else if (cur_end) st <= S_IDLE;
          else st <= S_WAIT;
        S_WAIT:
          if (preempt) begin
            st <= S_SUSP;
            if (!res) ptr <= sub;
          end else if (conv_done) begin
            if (ptr == LAST) st <= S_IDLE;
            else begin
              ptr <= ptr + 1'b1;
              if (cur_pause) begin
                sub <= ptr + 1'b1;
                st  <= S_PAUSE;
              end else st <= S_ISSUE;
            end
          end
        S_PAUSE:
          if (trig) st <= S_ISSUE;
        S_SUSP:
          if (!preempt) st <= S_ISSUE;
        default: st <= S_IDLE;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {cie, pie, arm, res} <= '0;
      mode <= '0;
      bq   <= '1;
    end else if (ctl_we) begin
      cie  <= ctl_wdata[15];
      pie  <= ctl_wdata[14];
      arm  <= ctl_wdata[13];
      mode <= ctl_wdata[12:8];
      res  <= ctl_wdata[7];
      bq   <= ctl_wdata[6:0];
    end else if (q_done) arm <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cflag <= 1'b0;
      pflag <= 1'b0;
    end else begin
      if (q_done) cflag <= 1'b1;
      else if (flag_clr[1]) cflag <= 1'b0;
      if (p_hit) pflag <= 1'b1;
      else if (flag_clr[0]) pflag <= 1'b0;
    end
endmodule

module adc_cmd_sequencer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_we,
  input logic [15:0] ctl_rdata,
  input logic [1:0]  flag_clr,
  input logic        preempt,
  input logic        conv_start,
  input logic        irq_cmpl,
  input logic        irq_pause
);
  assert_arm_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[13] == 1'b0);
  assert_start_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  assert_no_start_preempt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    preempt |-> !conv_start);
  assert_cmpl_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cmpl |-> ctl_rdata[15]);
  assert_pause_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pause |-> ctl_rdata[14]);
  assert_cmpl_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cmpl && !flag_clr[1] && !ctl_we |=> irq_cmpl);
  assert_pause_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pause && !flag_clr[0] && !ctl_we |=> irq_pause);
endmodule

bind adc_cmd_sequencer adc_cmd_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_rdata(ctl_rdata),
  .flag_clr(flag_clr), .preempt(preempt), .conv_start(conv_start),
  .irq_cmpl(irq_cmpl), .irq_pause(irq_pause)
);

// File: tb/sim_adc_cmd_sequencer.sv
module sim_adc_cmd_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 6;

  logic clk = 0, rst_n = 0, ctl_we = 0, ccw_we = 0, trig = 0, preempt = 0, conv_done = 0;
  logic [15:0] ctl_wdata = '0;
  logic [15:0] ctl_rdata;
  logic [1:0] flag_clr = '0;
  logic [6:0] ccw_addr = '0;
  logic [6:0] ccw_wdata = '0;
  logic conv_start, irq_cmpl, irq_pause;
  logic [5:0] conv_chan;

  int total = 0, bad = 0, logn = 0, cnt = 0;
  int logch [64];
  int qch [128];

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_cmd_sequencer u0 (.*);

  initial forever begin
    @(negedge clk);
    conv_done = 0;
    if (conv_start) begin
      if (logn < 64) logch[logn] = conv_chan;
      logn++;
      cnt = LAT;
    end else if (cnt > 0) begin
      if (preempt) cnt = 0;
      else begin
        cnt--;
        if (cnt == 0) conv_done = 1;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input bit ce, input bit pe, input bit a, input int m, input bit r, input int b);
    @(negedge clk);
    ctl_we = 1;
    ctl_wdata = {ce, pe, a, m[4:0], r, b[6:0]};
    @(negedge clk);
    ctl_we = 0;
  endtask

  task automatic load(input int addr, input bit p, input int ch);
    @(negedge clk);
    ccw_we = 1; ccw_addr = addr[6:0]; ccw_wdata = {p, ch[5:0]};
    @(negedge clk);
    ccw_we = 0;
  endtask

  task automatic clr_flags();
    @(negedge clk); flag_clr = 2'b11;
    @(negedge clk); flag_clr = 2'b00;
  endtask

  task automatic pulse_trig(input int wait_cyc);
    @(negedge clk); trig = 1;
    @(negedge clk); trig = 0;
    repeat (wait_cyc) @(negedge clk);
  endtask

  task automatic hold_preempt(input int target);
    wait (logn == target);
    @(negedge clk); preempt = 1;
    repeat (4) @(negedge clk);
    chk("R10 no start under preempt", logn, target);
    preempt = 0;
  endtask

  task automatic chk_log(input string req, input int n);
    chk(req, logn, n);
    for (int i = 0; i < n && i < 64; i++) chk(req, logch[i], qch[i]);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ctl reset", ctl_rdata, 16'h007F);
    chk("R1 start", conv_start, 0);
    chk("R1 irq", irq_cmpl | irq_pause, 0);
    rst_n = 1;
    @(negedge clk);

    wr_ctl(1, 0, 1, 5'h1A, 1, 7'h35);
    chk("R2 readback", ctl_rdata, {1'b1, 1'b0, 1'b0, 5'h1A, 1'b1, 7'h35});
    wr_ctl(0, 1, 1, 5'h05, 0, 7'h4A);
    chk("R2 R3 readback", ctl_rdata, {1'b0, 1'b1, 1'b0, 5'h05, 1'b0, 7'h4A});

    foreach (qch[i]) qch[i] = 0;
    for (int bi = 0; bi < 4; bi++) begin
      for (int len = 0; len <= 6; len++) begin
        int bq;
        bq = (bi == 0) ? 0 : (bi == 1) ? 9 : (bi == 2) ? 60 : 119;
        for (int i = 0; i < len; i++) begin
          qch[i] = (bq * 3 + i * 5 + 1) % 63;
          load(bq + i, 0, qch[i]);
        end
        load(bq + len, 0, 63);
        wr_ctl(1, 0, 1, 1, 0, bq);
        clr_flags();
        logn = 0;
        pulse_trig(80);
        chk_log("R4 R5 sweep", len);
        chk("R6 completion irq", irq_cmpl, 1);
        clr_flags();
        chk("R9 flag cleared", irq_cmpl, 0);
        pulse_trig(20);
        chk("R6 arm cleared", logn, len);
      end
    end

    for (int i = 0; i < 4; i++) begin
      qch[i] = 10 + i;
      load(124 + i, 0, qch[i]);
    end
    wr_ctl(1, 0, 1, 1, 0, 124);
    logn = 0;
    pulse_trig(60);
    chk_log("R6 end of memory", 4);
    chk("R6 end of memory irq", irq_cmpl, 1);
    clr_flags();

    for (int i = 0; i < 4; i++) begin
      qch[i] = 20 + i;
      load(30 + i, 0, qch[i]);
    end
    load(34, 0, 63);
    wr_ctl(1, 0, 0, 1, 0, 30);
    logn = 0;
    pulse_trig(40);
    chk("R4 unarmed trigger", logn, 0);
    wr_ctl(1, 0, 1, 2, 0, 30);
    pulse_trig(40);
    chk("R4 wrong mode", logn, 0);

    wr_ctl(1, 0, 1, 1, 0, 30);
    @(negedge clk); trig = 1;
    @(negedge clk); trig = 0;
    chk("R4 start next cycle", conv_start, 1);
    chk("R4 first channel", conv_chan, 20);
    wait (logn == 2);
    pulse_trig(60);
    chk_log("R7 trigger while running", 4);
    clr_flags();

    wr_ctl(0, 0, 1, 1, 0, 30);
    pulse_trig(60);
    chk("R9 gated off", irq_cmpl, 0);
    wr_ctl(1, 0, 0, 1, 0, 30);
    chk("R9 enable shows flag", irq_cmpl, 1);
    clr_flags();

    qch[0] = 40; qch[1] = 41; qch[2] = 42; qch[3] = 43;
    load(10, 0, 40); load(11, 1, 41); load(12, 0, 42); load(13, 0, 43); load(14, 0, 63);
    wr_ctl(1, 1, 1, 1, 0, 10);
    logn = 0;
    pulse_trig(80);
    chk("R8 stops at pause", logn, 2);
    chk("R8 pause irq", irq_pause, 1);
    chk("R8 no completion yet", irq_cmpl, 0);
    pulse_trig(80);
    chk_log("R8 continue", 4);
    chk("R8 completion", irq_cmpl, 1);
    clr_flags();
    chk("R9 pause cleared", irq_pause, 0);

    for (int i = 0; i < 6; i++) load(20 + i, 0, 50 + i);
    load(26, 0, 63);
    wr_ctl(1, 0, 1, 1, 1, 20);
    logn = 0;
    pulse_trig(0);
    hold_preempt(3);
    repeat (80) @(negedge clk);
    qch[0] = 50; qch[1] = 51; qch[2] = 52; qch[3] = 52; qch[4] = 53; qch[5] = 54; qch[6] = 55;
    chk_log("R10 resume aborted", 7);
    clr_flags();

    wr_ctl(1, 0, 1, 1, 0, 20);
    logn = 0;
    pulse_trig(0);
    hold_preempt(3);
    repeat (80) @(negedge clk);
    qch[0] = 50; qch[1] = 51; qch[2] = 52;
    for (int i = 0; i < 6; i++) qch[3 + i] = 50 + i;
    chk_log("R10 restart queue", 9);
    clr_flags();

    load(21, 1, 51);
    wr_ctl(1, 1, 1, 1, 0, 20);
    logn = 0;
    pulse_trig(60);
    chk("R10 paused first", logn, 2);
    pulse_trig(0);
    hold_preempt(4);
    repeat (80) @(negedge clk);
    qch[0] = 50; qch[1] = 51; qch[2] = 52; qch[3] = 53;
    qch[4] = 52; qch[5] = 53; qch[6] = 54; qch[7] = 55;
    chk_log("R10 restart sub-queue", 8);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule